// File: doc/BRIEF.md
# Periodic Timer with Prescaler and Postscaler

This block is an 8-bit periodic timer on a small register bus. An external clock-enable tick, normally one pulse every fourth system clock, passes through a selectable prescaler. The prescaler advances an 8-bit up-counter. The counter is compared with a writable period register. On the increment after the counter equals the period, the counter returns to zero and a match event occurs.

Each match event is exported undivided as a one-cycle pulse that a companion synchronous serial port can use as its shift-clock source. The same events also drive a postscaler. When the postscaler reaches its programmed count, it sets a sticky interrupt flag. The interrupt request is the flag gated by an enable bit. Software programs the block through four byte-wide registers. Reads are combinational and have no side effects.

Top module: `period_timer`

## Requirements
- R1: After reset, the register at address 0 (control) reads 0x00, address 1 (count) reads 0x00, address 2 (period) reads 0xFF and address 3 (interrupt) reads 0x00, and both `match_pulse` and `irq` are low.
- R2: The control register has the following layout: bits 6:3 are the postscale select, bit 2 is the run enable, and bits 1:0 are the prescale select. Bit 7 is not implemented and always reads 0, so writing 0xFF reads back as 0x7F.
- R3: While running, the counter advances on every qualifying `tick_in` when the prescale select is 00, on every 4th tick when it is 01, and on every 16th tick when it is 10 or 11.
- R4: The counter counts up from 0x00. On the advance after it equals the period register, it returns to 0x00 instead of incrementing. `match_pulse` is high for exactly the one cycle in which the count first reads 0x00 after such a wrap.
- R5: The period register can be read and written. If the count is above the period, the counter keeps incrementing, rolls from 0xFF to 0x00 without a match, and then matches when it reaches the period.
- R6: With postscale select n, the interrupt flag (address 3, bit 0) is set on every (n+1)-th match event. The flag becomes visible in the same cycle as that match's `match_pulse`.
- R7: Once set, the interrupt flag stays set until software writes 0 to bit 0 of address 3. Bit 1 of address 3 is the interrupt enable, and `irq` equals flag AND enable.
- R8: While the run bit is 0, ticks change neither the count nor the prescaler or postscaler progress, and `match_pulse` stays low.
- R9: Any write to the count or control register discards the progress of both the prescaler and the postscaler. Such a write does not change the period register.
- R10: If a count-register write and a counter advance fall in the same cycle, the written value is loaded and the advance is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_in | input | 1 | Count clock enable (system clock / 4 pulse) |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 count, 2 period, 3 interrupt |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| match_pulse | output | 1 | One-cycle pulse per period match, before the postscaler |
| irq | output | 1 | Interrupt request, flag AND enable |

## Verification
The embedded assertions check the following properties on every cycle:
- Both divider counters stay within their programmed terminal values.
- The counter either holds, increments by one, wraps to zero with a match pulse, or loads the written value.
- The interrupt flag stays set until it is explicitly cleared.
- No match pulse follows a cycle in which the run bit is off.

The directed scenarios are needed for the properties that span many cycles:
- The exact divide ratios of each prescale and postscale setting.
- The 0xFF rollover when the count is above the period.
- The discarding of divider progress after register writes.
- The register map as seen from the bus.

// File: rtl/ptmr_pkg.sv
// Package: ptmr_pkg
// Shared constants, register addresses, the control-register layout and the
// prescale decode for the periodic timer. Assumes an 8-bit register bus.
package ptmr_pkg;

    localparam int DATA_W = 8;
    localparam int PRE_W  = 4;
    localparam int POST_W = 4;

    typedef enum logic [1:0] {
        ADDR_CTRL   = 2'd0,
        ADDR_COUNT  = 2'd1,
        ADDR_PERIOD = 2'd2,
        ADDR_IRQ    = 2'd3
    } ptmr_addr_e;

    // Control register, bits 6:0 (bit 7 is not stored)
    typedef struct packed {
        logic [POST_W-1:0] post_sel;
        logic              run;
        logic [1:0]        pre_sel;
    } ptmr_ctrl_t;

    // Terminal value of the prescaler counter for a given select
    function automatic logic [PRE_W-1:0] pre_terminal(input logic [1:0] sel);
        logic [PRE_W-1:0] term;
        case (sel)
            2'b00:   term = PRE_W'(0);
            2'b01:   term = PRE_W'(3);
            default: term = PRE_W'(15);
        endcase
        return term;
    endfunction

endpackage

// File: rtl/ptmr_event_div.sv
// Module: ptmr_event_div
// Counts step events from 0 up to a terminal value. On the step that finds
// the counter at the terminal value, it emits a combinational carry and
// restarts from 0. It serves as both the prescaler and the postscaler.
// Assumes the terminal value changes only in a cycle that also asserts clr,
// so the counter never sits above it.
module ptmr_event_div #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [DIV_W-1:0] last,
    output logic             carry
);

    logic [DIV_W-1:0] div_q;

    // Carry on the step that completes a full ratio; a clear suppresses it
    assign carry = step && !clr && (div_q == last);

    // Progress counter: clear, restart after carry, or advance on a step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (clr) begin
            div_q <= '0;
        end else if (step) begin
            div_q <= carry ? '0 : div_q + 1'b1;
        end
    end

    // R3
    div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_q <= last);

    // R3
    div_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry |=> (div_q == '0));

    // R9
    div_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (div_q == '0));

    // R8
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clr) |=> $stable(div_q));

endmodule

// File: rtl/ptmr_counter.sv
// Module: ptmr_counter
// The up-counter and period comparator. An advance while the count equals
// the period wraps the count to 0 and raises a hit. A load from the bus
// takes priority over an advance in the same cycle. hit_q is the registered
// match pulse, high in the cycle after the wrap edge.
module ptmr_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] period,
    output logic [W-1:0] count,
    output logic         hit,
    output logic         hit_q
);

    logic [W-1:0] cnt_q;

    assign count = cnt_q;

    // Comparator: a match needs an advance that a load does not override
    assign hit = inc && !load && (cnt_q == period);

    // Count register: load wins, then wrap on match, then plain increment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (hit) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Match pulse register, aligned with the count reading zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
        end else begin
            hit_q <= hit;
        end
    end

    // R4
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (cnt_q == '0) && hit_q);

    // R5
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load && !hit) |=> (cnt_q == W'($past(cnt_q) + 1'b1)) && !hit_q);

    // R10
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val)) && !hit_q);

    // R8
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !load) |=> $stable(cnt_q) && !hit_q);

endmodule

// File: rtl/ptmr_regs.sv
// Module: ptmr_regs
// The register file: control, period, interrupt flag and enable, the write
// decode that loads the count and clears the dividers, and the read
// multiplexer. A postscaler terminal event sets the flag and wins over a
// software write to the flag in the same cycle.
module ptmr_regs
    import ptmr_pkg::*;
#(
    parameter logic [DATA_W-1:0] PERIOD_RESET = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] count_val,
    input  logic              post_done,
    output ptmr_ctrl_t        ctrl,
    output logic [DATA_W-1:0] period,
    output logic              cnt_load,
    output logic              div_clr,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    localparam int CTRL_W = $bits(ptmr_ctrl_t);

    ptmr_ctrl_t        ctrl_q;
    logic [DATA_W-1:0] period_q;
    logic              flag_q;
    logic              ie_q;
    logic              wr_ctrl;
    logic              wr_count;
    logic              wr_period;
    logic              wr_irq;

    // Write decode per register
    always_comb begin
        wr_ctrl   = bus_wr && (bus_addr == ADDR_CTRL);
        wr_count  = bus_wr && (bus_addr == ADDR_COUNT);
        wr_period = bus_wr && (bus_addr == ADDR_PERIOD);
        wr_irq    = bus_wr && (bus_addr == ADDR_IRQ);
    end

    assign cnt_load = wr_count;
    assign div_clr  = wr_ctrl || wr_count;
    assign ctrl     = ctrl_q;
    assign period   = period_q;
    assign irq      = flag_q && ie_q;

    // Control register storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= ptmr_ctrl_t'(bus_wdata[CTRL_W-1:0]);
        end
    end

    // Period register storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= PERIOD_RESET;
        end else if (wr_period) begin
            period_q <= bus_wdata;
        end
    end

    // Interrupt enable and sticky flag; the hardware set wins over a write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            ie_q   <= 1'b0;
        end else begin
            if (wr_irq) begin
                ie_q <= bus_wdata[1];
            end
            if (post_done) begin
                flag_q <= 1'b1;
            end else if (wr_irq) begin
                flag_q <= bus_wdata[0];
            end
        end
    end

    // Read multiplexer
    always_comb begin
        case (ptmr_addr_e'(bus_addr))
            ADDR_CTRL:   bus_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
            ADDR_COUNT:  bus_rdata = count_val;
            ADDR_PERIOD: bus_rdata = period_q;
            default:     bus_rdata = {{(DATA_W-2){1'b0}}, ie_q, flag_q};
        endcase
    end

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(wr_irq && !bus_wdata[0])) |=> flag_q);

    // R6
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        post_done |=> flag_q);

    // R9
    period_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_period |=> $stable(period_q));

endmodule

// File: rtl/period_timer.sv
// Module: period_timer
// Top level of the periodic timer. It chains the run-gated tick, the
// prescaler, the counter/comparator and the postscaler, with the register
// file in front. match_pulse leaves before the postscaler. Assumes tick_in
// is already synchronous to clk.
module period_timer
    import ptmr_pkg::*;
#(
    parameter logic [DATA_W-1:0] PERIOD_RESET = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_in,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              match_pulse,
    output logic              irq
);

    ptmr_ctrl_t        ctrl;
    logic [DATA_W-1:0] period;
    logic [DATA_W-1:0] count;
    logic              cnt_load;
    logic              div_clr;
    logic              pre_step;
    logic              cnt_inc;
    logic              hit;
    logic              hit_q;
    logic              post_done;

    // Ticks count only while the run bit is set
    assign pre_step    = tick_in && ctrl.run;
    assign match_pulse = hit_q;

    ptmr_regs #(
        .PERIOD_RESET(PERIOD_RESET)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .count_val (count),
        .post_done (post_done),
        .ctrl      (ctrl),
        .period    (period),
        .cnt_load  (cnt_load),
        .div_clr   (div_clr),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    ptmr_event_div #(
        .DIV_W(PRE_W)
    ) u_prescale (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (div_clr),
        .step  (pre_step),
        .last  (pre_terminal(ctrl.pre_sel)),
        .carry (cnt_inc)
    );

    ptmr_counter #(
        .W(DATA_W)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (cnt_inc),
        .load     (cnt_load),
        .load_val (bus_wdata),
        .period   (period),
        .count    (count),
        .hit      (hit),
        .hit_q    (hit_q)
    );

    ptmr_event_div #(
        .DIV_W(POST_W)
    ) u_postscale (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (div_clr),
        .step  (hit),
        .last  (ctrl.post_sel),
        .carry (post_done)
    );

    // R8
    stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.run |=> !match_pulse);

    // R7
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (bus_addr != ADDR_IRQ) || (bus_rdata[1:0] == 2'b11));

endmodule

// File: tb/test_period_timer.sv
module test_period_timer;

    localparam int CLK_PERIOD = 10;

    logic       clk;
    logic       rst_n;
    logic       tick_in;
    logic       bus_wr;
    logic [1:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       match_pulse;
    logic       irq;

    int  checks;
    int  failures;
    bit  finished;

    // Reference state derived from the requirements
    int  m_pre, m_post, m_cnt, m_period, m_pre_div, m_post_div;
    bit  m_run, m_flag, m_ie, m_match;

    period_timer i_period_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_in     (tick_in),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .match_pulse (match_pulse),
        .irq         (irq)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD / 2) clk = ~clk;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic set_ctrl_model(input int v);
        m_run      = v[2];
        m_pre_div  = ((v & 3) == 0) ? 1 : (((v & 3) == 1) ? 4 : 16);
        m_post_div = ((v >> 3) & 15) + 1;
    endtask

    task automatic model_tick();
        if (m_run) begin
            m_pre++;
            if (m_pre == m_pre_div) begin
                m_pre = 0;
                if (m_cnt == m_period) begin
                    m_cnt   = 0;
                    m_match = 1'b1;
                    m_post++;
                    if (m_post == m_post_div) begin
                        m_post = 0;
                        m_flag = 1'b1;
                    end
                end else begin
                    m_cnt = (m_cnt + 1) % 256;
                end
            end
        end
    endtask

    task automatic wr(input int a, input int d, input bit tk = 1'b0);
        bus_wr    = 1'b1;
        bus_addr  = 2'(a);
        bus_wdata = 8'(d);
        tick_in   = tk;
        @(posedge clk);
        m_match = 1'b0;
        case (a)
            0: begin set_ctrl_model(d); m_pre = 0; m_post = 0; end
            1: begin m_cnt = d & 255; m_pre = 0; m_post = 0; end
            2: begin m_period = d & 255; if (tk) model_tick(); end
            default: begin
                m_ie = d[1]; m_flag = d[0];
                if (tk) model_tick();
            end
        endcase
        @(negedge clk);
        bus_wr   = 1'b0;
        tick_in  = 1'b0;
        bus_addr = 2'd1;
    endtask

    task automatic expect_reg(input string req, input int a, input int e);
        bus_addr = 2'(a);
        #1;
        chk(req, int'(bus_rdata), e);
        bus_addr = 2'd1;
    endtask

    task automatic run_ticks(input string req, input int n);
        repeat (n) begin
            tick_in = 1'b1;
            @(posedge clk);
            m_match = 1'b0;
            model_tick();
            @(negedge clk);
            chk({req, " match_pulse"}, int'(match_pulse), int'(m_match));
            chk({req, " count"}, int'(bus_rdata), m_cnt);
        end
        tick_in = 1'b0;
        chk({req, " irq"}, int'(irq), int'(m_flag && m_ie));
    endtask

    task automatic t_reset();
        expect_reg("R1 ctrl", 0, 'h00);
        expect_reg("R1 count", 1, 'h00);
        expect_reg("R1 period", 2, 'hFF);
        expect_reg("R1 irqreg", 3, 'h00);
        chk("R1 irq", int'(irq), 0);
        chk("R1 match_pulse", int'(match_pulse), 0);
    endtask

    task automatic t_ctrl_map();
        wr(0, 'hFF);
        expect_reg("R2 msb reads 0", 0, 'h7F);
        wr(0, 'h00);
        expect_reg("R2 cleared", 0, 'h00);
    endtask

    task automatic t_stopped();
        wr(1, 'hFE);
        run_ticks("R8", 20);
        expect_reg("R8 count held", 1, 'hFE);
        expect_reg("R8 no flag", 3, 'h00);
    endtask

    task automatic t_prescale();
        wr(1, 0);
        wr(2, 3);
        wr(0, 'h04);
        run_ticks("R4 div1", 10);
        wr(0, 'h05);
        run_ticks("R3 div4", 20);
        wr(0, 'h06);
        run_ticks("R3 div16 sel10", 40);
        wr(0, 'h07);
        run_ticks("R3 div16 sel11", 34);
    endtask

    task automatic t_postscale();
        wr(0, 0);
        wr(1, 0);
        wr(3, 0);
        wr(2, 1);
        wr(0, 'h14);
        run_ticks("R6 post3", 5);
        expect_reg("R6 flag not yet", 3, 'h00);
        run_ticks("R6 post3", 1);
        expect_reg("R6 flag set", 3, 'h01);
        chk("R7 irq masked", int'(irq), 0);
        wr(3, 3);
        chk("R7 irq enabled", int'(irq), 1);
        run_ticks("R7 sticky", 7);
        expect_reg("R7 flag kept", 3, 'h03);
        wr(3, 2);
        expect_reg("R7 flag cleared", 3, 'h02);
        chk("R7 irq low", int'(irq), 0);
        wr(0, 0);
        wr(2, 0);
        wr(1, 0);
        wr(3, 0);
        wr(0, 'h7C);
        run_ticks("R6 post16", 15);
        expect_reg("R6 post16 not yet", 3, 'h00);
        run_ticks("R6 post16", 1);
        expect_reg("R6 post16 set", 3, 'h01);
    endtask

    task automatic t_clear();
        wr(0, 0);
        wr(3, 0);
        wr(2, 'hFF);
        wr(1, 0);
        wr(0, 'h05);
        run_ticks("R9 pre", 3);
        wr(0, 'h05);
        run_ticks("R9 pre after clear", 3);
        expect_reg("R9 count no step", 1, 'h00);
        run_ticks("R9 pre", 1);
        expect_reg("R9 count stepped", 1, 'h01);
        expect_reg("R9 period kept", 2, 'hFF);
        wr(0, 0);
        wr(2, 0);
        wr(1, 0);
        wr(3, 0);
        wr(0, 'h1C);
        run_ticks("R9 post", 3);
        wr(1, 0);
        run_ticks("R9 post after clear", 3);
        expect_reg("R9 post no flag", 3, 'h00);
        run_ticks("R9 post", 1);
        expect_reg("R9 post flag", 3, 'h01);
        expect_reg("R9 period kept", 2, 'h00);
    endtask

    task automatic t_beyond();
        wr(0, 0);
        wr(3, 0);
        wr(1, 'h10);
        wr(2, 5);
        wr(0, 'h04);
        run_ticks("R5 rollover", 240);
        expect_reg("R5 rolled to 0", 1, 'h00);
        run_ticks("R5 then match", 6);
        expect_reg("R5 period readback", 2, 'h05);
    endtask

    task automatic t_write_wins();
        wr(0, 'h04);
        wr(2, 'hFF);
        wr(1, 'h40, 1'b1);
        expect_reg("R10 load wins", 1, 'h40);
        run_ticks("R10 next step", 1);
    endtask

    initial begin
        checks    = 0;
        failures  = 0;
        finished  = 1'b0;
        rst_n     = 1'b0;
        tick_in   = 1'b0;
        bus_wr    = 1'b0;
        bus_addr  = 2'd1;
        bus_wdata = 8'h00;
        m_pre = 0; m_post = 0; m_cnt = 0; m_period = 255;
        m_flag = 1'b0; m_ie = 1'b0; m_match = 1'b0;
        set_ctrl_model(0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl_map();
        t_stopped();
        t_prescale();
        t_postscale();
        t_clear();
        t_beyond();
        t_write_wins();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule